// File: doc/BRIEF.md
# JTAG Bit-Shift Master

This block turns simple host commands into JTAG pin activity. It drives TCK, TMS and TDI toward a target TAP controller and samples TDO. The host can put the TAP into Test-Logic-Reset and then Run-Test/Idle. It can walk the TAP into Shift-IR or Shift-DR. It can shift a word of 1 to 32 bits through the selected register. The host controls each step and must issue the walk command before the shift.

Each shift command carries three options of its own: the bit order, whether TMS goes high on the last bit so that the TAP leaves Shift, and whether the walk then continues to Run-Test/Idle. When the TAP is left in Shift, the next shift command continues the same register. A caller can therefore build one DR scan from several pieces, for example a 5-bit field followed by a single flag bit. TCK is derived from the system clock: each TCK phase lasts a programmable number of system clocks. The block returns the captured TDO word and raises a one-cycle completion pulse when the command ends.

Top module: `jtag_shift_master`

## Requirements
- R1: After reset, busy_o=0, done_o=0, tck_o=1, tms_o=0, tdi_o=0 and rdata_o=0.
- R2: While a command runs, every low phase and every high phase of tck_o lasts exactly div_i+1 system clocks. tck_o stays high whenever busy_o is low.
- R3: Op code 2'b00 (TAP reset) produces RST_ONES rising TCK edges with TMS high (default 5), followed by one edge with TMS low. That is 6 edges in total.
- R4: Op code 2'b01 (go to Shift-IR) produces four edges with TMS 1,1,0,0. Op code 2'b10 (go to Shift-DR) produces three edges with TMS 1,0,0.
- R5: Op code 2'b11 (shift) produces cmd_len_m1_i+1 data edges. With cmd_msb_first_i=0, TDI on data edge k carries cmd_data_i[k].
- R6: With cmd_msb_first_i=1, TDI on data edge k carries cmd_data_i[n-1-k], where n is the shift length. The TDO bit captured on edge k lands in rdata_o[n-1-k].
- R7: With cmd_msb_first_i=0, the TDO bit captured on data edge k lands in rdata_o[k]. In both orders, the rdata_o bits at index n and above are 0. rdata_o changes only in the cycle done_o is high.
- R8: With cmd_exit_i=1, TMS is high on the last data edge only. With cmd_exit_i=0, TMS is low on every data edge and no further edges follow, so a later shift continues the same register.
- R9: With cmd_exit_i=1 and cmd_idle_i=1, two edges follow the data edges, with TMS 1 then 0. With cmd_exit_i=1 and cmd_idle_i=0, one edge with TMS 1 follows. With cmd_exit_i=0, cmd_idle_i has no effect.
- R10: busy_o rises in the cycle after cmd_valid_i is accepted and stays high until done_o. done_o is a single-cycle pulse in the first cycle that busy_o is low again. A command presented while busy_o is high is ignored.
- R11: TDO is captured at the system clock edge where tck_o rises.
- R12: tms_o and tdi_o do not change while tck_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | TCK half-period minus one, in system clocks |
| cmd_valid_i | input | 1 | Command strobe; accepted when busy_o is low |
| cmd_op_i | input | 2 | 00 TAP reset, 01 go to Shift-IR, 10 go to Shift-DR, 11 shift |
| cmd_len_m1_i | input | $clog2(WORD_W) | Shift length minus one |
| cmd_data_i | input | WORD_W | Bits to send on TDI |
| cmd_msb_first_i | input | 1 | 1 sends and assembles MSB first |
| cmd_exit_i | input | 1 | TMS high on the last data bit |
| cmd_idle_i | input | 1 | Continue to Run-Test/Idle after leaving Shift |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | WORD_W | Captured TDO word of the last shift |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The phase-length check assumes that div_i is held constant while busy_o is high. The pin-stability check assumes that command fields matter only in the accept cycle. The bench therefore changes the divider only between commands and drives command fields for a single cycle. The target model changes TDO only on falling TCK edges, well before each rising edge. This keeps the capture instant unambiguous. The bench records TMS, TDI and TDO at every rising TCK edge and compares that log with expected patterns derived from the command options.

// File: rtl/jtag_shift_pkg.sv
`timescale 1ns/1ps
package jtag_shift_pkg;
  typedef enum logic [1:0] {
    OP_TAP_RESET = 2'd0,
    OP_GOTO_IR   = 2'd1,
    OP_GOTO_DR   = 2'd2,
    OP_SHIFT     = 2'd3
  } jtag_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_DATA,
    ST_POST
  } walk_st_e;
endpackage

// File: rtl/jtag_tck_gen.sv
`timescale 1ns/1ps
module jtag_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             high_q;
  logic             at_lim;

  assign at_lim = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (at_lim) begin
      cnt_q  <= '0;
      high_q <= ~high_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // idle parks TCK high; each bit is a low phase then a high phase
  assign tck_o     = ~en_i | high_q;
  assign rise_o    = en_i & ~high_q & at_lim;
  assign bit_end_o = en_i & high_q & at_lim;
endmodule

// File: rtl/jtag_word_shifter.sv
`timescale 1ns/1ps
module jtag_word_shifter #(
  parameter int WORD_W = 32,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              msb_first_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              tdo_i,
  output logic              tdi_o,
  output logic [WORD_W-1:0] result_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic              msb_q;

  // reverse the low m+1 bits, clear the rest
  function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] x,
                                             input logic [LEN_W-1:0] m);
    logic [WORD_W-1:0] r;
    logic [LEN_W-1:0]  j;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i <= int'(m)) begin
        j    = m - LEN_W'(i);
        r[i] = x[j];
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      idx_q <= '0;
      len_q <= '0;
      msb_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= msb_first_i ? flip(data_i, len_m1_i) : data_i;
      rx_q  <= '0;
      idx_q <= '0;
      len_q <= len_m1_i;
      msb_q <= msb_first_i;
    end else begin
      if (shift_i) tx_q <= tx_q >> 1;
      if (sample_i) begin
        rx_q[idx_q] <= tdo_i;
        idx_q       <= idx_q + 1'b1;
      end
    end
  end

  assign tdi_o    = tx_q[0];
  assign result_o = msb_q ? flip(rx_q, len_q) : rx_q;
endmodule

// File: rtl/jtag_shift_master.sv
`timescale 1ns/1ps
module jtag_shift_master
  import jtag_shift_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 32,
  parameter int RST_ONES = 5,
  localparam int LEN_W   = $clog2(WORD_W),
  localparam int DL_W    = LEN_W + 1,
  localparam int PAT_W   = RST_ONES + 1,
  localparam int CNT_W   = $clog2(PAT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [LEN_W-1:0]  cmd_len_m1_i,
  input  logic [WORD_W-1:0] cmd_data_i,
  input  logic              cmd_msb_first_i,
  input  logic              cmd_exit_i,
  input  logic              cmd_idle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  walk_st_e          st_q;
  logic [PAT_W-1:0]  pat_q;
  logic [CNT_W-1:0]  pat_left_q;
  logic [DL_W-1:0]   data_left_q;
  logic              exit_q, idle_q, done_q;
  logic [WORD_W-1:0] rdata_q;
  logic              tms_hold_q, tdi_hold_q;

  logic              busy, accept, rise, bit_end;
  logic              last_data, cur_tms, cur_tdi, sh_tdi;
  logic [WORD_W-1:0] sh_result;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_valid_i & ~busy;
  assign last_data = (data_left_q == DL_W'(1));

  jtag_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (busy),
    .div_i     (div_i),
    .tck_o     (tck_o),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  jtag_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept && jtag_op_e'(cmd_op_i) == OP_SHIFT),
    .data_i      (cmd_data_i),
    .len_m1_i    (cmd_len_m1_i),
    .msb_first_i (cmd_msb_first_i),
    .shift_i     (bit_end && st_q == ST_DATA),
    .sample_i    (rise && st_q == ST_DATA),
    .tdo_i       (tdo_i),
    .tdi_o       (sh_tdi),
    .result_o    (sh_result)
  );

  always_comb begin
    cur_tms = tms_hold_q;
    cur_tdi = tdi_hold_q;
    unique case (st_q)
      ST_WALK, ST_POST: begin cur_tms = pat_q[0];          cur_tdi = 1'b0;   end
      ST_DATA:          begin cur_tms = exit_q & last_data; cur_tdi = sh_tdi; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pat_q       <= '0;
      pat_left_q  <= '0;
      data_left_q <= '0;
      exit_q      <= 1'b0;
      idle_q      <= 1'b0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
      tms_hold_q  <= 1'b0;
      tdi_hold_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy) begin
        tms_hold_q <= cur_tms;
        tdi_hold_q <= cur_tdi;
      end
      if (accept) begin
        unique case (jtag_op_e'(cmd_op_i))
          OP_TAP_RESET: begin
            pat_q      <= {1'b0, {RST_ONES{1'b1}}};
            pat_left_q <= CNT_W'(PAT_W);
            st_q       <= ST_WALK;
          end
          OP_GOTO_IR: begin
            pat_q      <= PAT_W'(4'b0011);
            pat_left_q <= CNT_W'(4);
            st_q       <= ST_WALK;
          end
          OP_GOTO_DR: begin
            pat_q      <= PAT_W'(3'b001);
            pat_left_q <= CNT_W'(3);
            st_q       <= ST_WALK;
          end
          default: begin
            data_left_q <= {1'b0, cmd_len_m1_i} + DL_W'(1);
            exit_q      <= cmd_exit_i;
            idle_q      <= cmd_idle_i;
            st_q        <= ST_DATA;
          end
        endcase
      end else if (bit_end) begin
        unique case (st_q)
          ST_DATA: begin
            data_left_q <= data_left_q - DL_W'(1);
            if (last_data) begin
              if (exit_q) begin
                // Exit1 -> Update, optionally on to Run-Test/Idle
                st_q       <= ST_POST;
                pat_q      <= idle_q ? PAT_W'(2'b01) : PAT_W'(1'b1);
                pat_left_q <= idle_q ? CNT_W'(2) : CNT_W'(1);
              end else begin
                st_q    <= ST_IDLE;
                done_q  <= 1'b1;
                rdata_q <= sh_result;
              end
            end
          end
          ST_WALK, ST_POST: begin
            pat_q      <= pat_q >> 1;
            pat_left_q <= pat_left_q - CNT_W'(1);
            if (pat_left_q == CNT_W'(1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              if (st_q == ST_POST) rdata_q <= sh_result;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o  = busy;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign tms_o   = busy ? cur_tms : tms_hold_q;
  assign tdi_o   = busy ? cur_tdi : tdi_hold_q;
endmodule

// File: rtl/jtag_shift_master_chk.sv
`timescale 1ns/1ps
module jtag_shift_master_chk #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DIV_W-1:0]  div_i,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              tck_o,
  input logic              tms_o,
  input logic              tdi_o
);
  logic [DIV_W:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_run_q <= '0;
    else if (tck_o) low_run_q <= '0;
    else            low_run_q <= low_run_q + 1'b1;
  end

  assert_idle_tck_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tck_o);

  assert_low_phase_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tck_o) |-> low_run_q == ({1'b0, div_i} + 1'b1));

  assert_pins_hold_high_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  assert_done_ends_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_busy_needs_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_rdata_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
endmodule

bind jtag_shift_master jtag_shift_master_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/jtag_shift_master_test.sv
`timescale 1ns/1ps
module jtag_shift_master_test;
  localparam int DIV_W = 8;
  localparam int WORD_W = 32;
  localparam int LEN_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div = '0;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = '0;
  logic [LEN_W-1:0]  cmd_len_m1 = '0;
  logic [WORD_W-1:0] cmd_data = '0;
  logic              cmd_msb = 1'b0, cmd_exit = 1'b0, cmd_idle = 1'b0;
  logic              busy_o, done_o, tck_o, tms_o, tdi_o;
  logic              tdo_i = 1'b0;
  logic [WORD_W-1:0] rdata_o;

  always #4 clk = ~clk;

  jtag_shift_master uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_len_m1_i(cmd_len_m1), .cmd_data_i(cmd_data),
    .cmd_msb_first_i(cmd_msb), .cmd_exit_i(cmd_exit), .cmd_idle_i(cmd_idle),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
  );

  int n_checks = 0, n_fail = 0;
  logic tms_log [64];
  logic tdi_log [64];
  logic tdo_log [64];
  int n_edge = 0, bad_phase = 0;
  time t_fall = 0, t_rise = 0;
  logic [15:0] lfsr = 16'hACE1;

  // target model: TDO moves on falling TCK, pins logged on rising TCK
  always @(negedge tck_o) if (rst_n) begin
    t_fall = $time;
    if (n_edge > 0 && int'(($time - t_rise) / 8) != int'(div) + 1) bad_phase++;
    tdo_i = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always @(posedge tck_o) if (rst_n && busy_o) begin
    t_rise = $time;
    if (int'(($time - t_fall) / 8) != int'(div) + 1) bad_phase++;
    if (n_edge < 64) begin
      tms_log[n_edge] = tms_o;
      tdi_log[n_edge] = tdi_o;
      tdo_log[n_edge] = tdo_i;
    end
    n_edge++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int len, input logic [31:0] data,
                       input logic msb, input logic ex, input logic idl);
    @(negedge clk);
    n_edge = 0;
    bad_phase = 0;
    cmd_op = op; cmd_len_m1 = LEN_W'(len - 1); cmd_data = data;
    cmd_msb = msb; cmd_exit = ex; cmd_idle = idl; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  function automatic logic [31:0] tms_bits(input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n && i < 32; i++) v[i] = tms_log[i];
    return v;
  endfunction

  task automatic t_reset_state();
    check({busy_o, done_o, tck_o, tms_o, tdi_o} == 5'b00100, "R1 pins",
          {27'd0, busy_o, done_o, tck_o, tms_o, tdi_o}, 32'b00100);
    check(rdata_o == '0, "R1 rdata", rdata_o, 0);
  endtask

  task automatic t_tap_reset();
    issue(2'b00, 1, 0, 0, 0, 0);
    wait_done();
    check(n_edge == 6, "R3 edge count", n_edge, 6);
    check(tms_bits(6) == 32'b011111, "R3 tms pattern", tms_bits(6), 32'b011111);
    check(bad_phase == 0, "R2 phase length", bad_phase, 0);
  endtask

  task automatic t_goto_ir();
    issue(2'b01, 1, 0, 0, 0, 0);
    wait_done();
    check(n_edge == 4, "R4 IR edges", n_edge, 4);
    check(tms_bits(4) == 32'b0011, "R4 IR tms", tms_bits(4), 32'b0011);
  endtask

  task automatic t_goto_dr();
    issue(2'b10, 1, 0, 0, 0, 0);
    wait_done();
    check(n_edge == 3, "R4 DR edges", n_edge, 3);
    check(tms_bits(3) == 32'b001, "R4 DR tms", tms_bits(3), 32'b001);
  endtask

  // generic shift with full pin and result checks
  task automatic do_shift(input int len, input logic [31:0] data, input logic msb,
                          input logic ex, input logic idl);
    int post;
    logic [31:0] exp_tdi, act_tdi, exp_tms, act_tms, exp_rd;
    post = ex ? (idl ? 2 : 1) : 0;
    issue(2'b11, len, data, msb, ex, idl);
    wait_done();
    check(n_edge == len + post, "R8/R9 edge count", n_edge, len + post);
    exp_tdi = '0; act_tdi = '0; exp_tms = '0; act_tms = '0; exp_rd = '0;
    for (int k = 0; k < len; k++) begin
      act_tdi[k] = tdi_log[k];
      exp_tdi[k] = msb ? data[len-1-k] : data[k];
      act_tms[k] = tms_log[k];
      exp_tms[k] = ex && (k == len - 1);
      if (msb) exp_rd[len-1-k] = tdo_log[k];
      else     exp_rd[k] = tdo_log[k];
    end
    check(act_tdi == exp_tdi, msb ? "R6 tdi order" : "R5 tdi order", act_tdi, exp_tdi);
    check(act_tms == exp_tms, "R8 tms on data", act_tms, exp_tms);
    if (post > 0) check(tms_log[len] == 1'b1, "R9 exit to update", tms_log[len], 1);
    if (post > 1) check(tms_log[len+1] == 1'b0, "R9 update to idle", tms_log[len+1], 0);
    check(rdata_o == exp_rd, msb ? "R6/R11 rdata" : "R7/R11 rdata", rdata_o, exp_rd);
    check(bad_phase == 0, "R2 phase length", bad_phase, 0);
  endtask

  task automatic t_shift_lsb_exit_idle();
    do_shift(8, 32'h0000_00A5, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_shift_msb_exit_park();
    do_shift(4, 32'h0000_000C, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_chained_partial();
    do_shift(5, 32'h0000_0013, 1'b0, 1'b0, 1'b0);
    do_shift(1, 32'h0000_0001, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_idle_without_exit();
    do_shift(1, 32'h1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_full_word_divs();
    div = 8'd0;
    do_shift(32, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1);
    div = 8'd3;
    do_shift(32, 32'h1234_5678, 1'b0, 1'b1, 1'b1);
    div = 8'd1;
  endtask

  task automatic t_busy_ignore();
    int stray_done = 0;
    logic busy_gap = 1'b0;
    issue(2'b11, 8, 32'h5A, 1'b0, 1'b1, 1'b1);
    check(busy_o == 1'b1, "R10 busy after accept", busy_o, 1);
    repeat (3) @(negedge clk);
    cmd_op = 2'b00; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done_o) begin
      if (!busy_o) busy_gap = 1'b1;
      @(negedge clk);
    end
    check(!busy_gap, "R10 busy held until done", busy_gap, 0);
    check(n_edge == 10, "R10 ignored command edges", n_edge, 10);
    @(negedge clk);
    check(done_o == 1'b0, "R10 done single pulse", done_o, 0);
    for (int i = 0; i < 40; i++) begin
      if (done_o || busy_o) stray_done++;
      @(negedge clk);
    end
    check(stray_done == 0, "R10 no stray command", stray_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    div = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tap_reset();
    t_goto_ir();
    t_shift_lsb_exit_idle();
    t_goto_dr();
    t_shift_msb_exit_park();
    t_goto_dr();
    t_chained_partial();
    t_idle_without_exit();
    t_full_word_divs();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule